// File: doc/BRIEF.md
# Programmable-Length Circular Segment Shifter

This block is a small animation engine for a segment display driver. It holds a pattern of segment bits in a register and rotates that pattern by one position each time a chosen frame-rate timer reports an overflow. A marquee or spinner effect then runs with no processor involvement. The register is up to 16 bits wide. Only its low `len` bits form the ring, so a shorter group of segment lines can be animated while the upper outputs stay dark.

Software programs the block through a single write strobe while the animation is stopped. The write sets the time base (one of three frame-counter overflow pulses), the rotation direction, the ring length and the starting pattern. Setting `enable` starts the animation. The registered `pattern_out` feeds the segment lines directly. Placing the bits onto physical common and segment pixels is done outside this block.

Top module: `circ_seg_shifter`

## Requirements
- R1: After reset `pattern_out` is 0, the ring length is 16, the direction is left and the time base is counter 0.
- R2: A write (`cfg_we` high while `enable` is low) makes `pattern_out` equal to `cfg_pattern` with every bit at or above the new length cleared, starting on the next cycle. The length field uses 1..16 as given and treats 0 or 17..31 as 16.
- R3: Bits of `pattern_out` at or above the programmed length are always zero.
- R4: With direction code 0 (left), one step moves bit i to bit i+1, and bit len-1 wraps into bit 0.
- R5: With direction code 1 (right), one step moves bit i to bit i-1, and bit 0 wraps into bit len-1.
- R6: Source code 0, 1 or 2 selects `tick[0]`, `tick[1]` or `tick[2]` as the time base. Code 3 selects none, so the pattern holds. Pulses on unselected tick lines have no effect.
- R7: Each cycle in which `enable` and the selected tick are both high produces exactly one step, and the step is visible on the next cycle. Consecutive pulses give consecutive steps.
- R8: While `enable` is low, no rotation happens, whatever the tick lines do.
- R9: A write while `enable` is high is ignored completely. Pattern, length, direction and source all keep their values, and the rotation continues unchanged.
- R10: With length 1, a step leaves bit 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the rotation and locks the configuration |
| tick | input | 3 | Overflow pulses from the three frame counters |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src | input | 2 | Time-base select (0..2, 3 = none) |
| cfg_dir | input | 1 | Direction, 0 left, 1 right |
| cfg_len | input | 5 | Ring length (0 or above 16 means 16) |
| cfg_pattern | input | 16 | Starting pattern |
| pattern_out | output | 16 | Current pattern driving the segment lines |

## Verification
Every result is registered once. A write or a step taken at a rising edge shows on `pattern_out` right after that same edge, and nothing waits longer. The bench drives the inputs on the falling edge and advances its own model at the rising edge using the inputs it applied. It then compares one nanosecond after that edge, so each comparison covers exactly one edge of effect. Held values (unselected tick, disabled, locked writes) are compared in the cycle that follows the stimulus, before any other stimulus can change the state.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

  localparam int unsigned LCS_MAXW = 32;

  // Ones in the low len positions.
  function automatic logic [31:0] lcs_mask(input int unsigned len);
    if (len >= LCS_MAXW) return 32'hFFFF_FFFF;
    return (32'h1 << len) - 32'h1;
  endfunction

  // Out-of-range length codes fall back to the full width.
  function automatic int unsigned lcs_clamp(input int unsigned raw, input int unsigned w);
    if (raw == 0 || raw > w) return w;
    return raw;
  endfunction

  // One circular step inside a ring of len bits; dir 0 = left, 1 = right.
  function automatic logic [31:0] lcs_rotate(input logic [31:0] p,
                                             input int unsigned len,
                                             input logic dir);
    logic [31:0] m;
    m = lcs_mask(len);
    if (len <= 1) return p & m;
    if (!dir) return ((p << 1) | (p >> (len - 1))) & m;
    return ((p >> 1) | ((p & 32'h1) << (len - 1))) & m;
  endfunction

endpackage

// File: rtl/lcs_cfg_regs.sv
module lcs_cfg_regs #(
  parameter int unsigned W  = 16,
  parameter int unsigned SW = 2,
  parameter int unsigned LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          cfg_we,
  input  logic [SW-1:0] cfg_src,
  input  logic          cfg_dir,
  input  logic [LW-1:0] cfg_len,
  output logic          load_evt,
  output logic [LW-1:0] load_len,
  output logic [SW-1:0] src_q,
  output logic          dir_q,
  output logic [LW-1:0] len_q
);
  import lcs_pkg::*;

  assign load_evt = cfg_we & ~enable;
  assign load_len = LW'(lcs_clamp(int'(cfg_len), W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dir_q <= 1'b0;
      len_q <= LW'(W);
    end else if (load_evt) begin
      src_q <= cfg_src;
      dir_q <= cfg_dir;
      len_q <= load_len;
    end
  end

  assert_cfg_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && enable) |=> $stable({src_q, dir_q, len_q}));

  assert_len_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q != '0) && (int'(len_q) <= W));

endmodule

// File: rtl/lcs_tick_sel.sv
module lcs_tick_sel #(
  parameter int unsigned NSRC = 3,
  parameter int unsigned SW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [NSRC-1:0] tick,
  input  logic [SW-1:0]   src,
  output logic            step_evt
);
  logic [NSRC-1:0] sel;

  for (genvar g = 0; g < NSRC; g++) begin : g_sel
    assign sel[g] = (src == SW'(g));
  end

  assign step_evt = enable & |(tick & sel);

  assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  assert_no_src_no_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(src) >= NSRC) |-> !step_evt);

  assert_idle_no_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !step_evt);

endmodule

// File: rtl/lcs_rot_core.sv
module lcs_rot_core #(
  parameter int unsigned W  = 16,
  parameter int unsigned LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_evt,
  input  logic [W-1:0]  load_pat,
  input  logic [LW-1:0] load_len,
  input  logic          step_evt,
  input  logic          dir,
  input  logic [LW-1:0] len,
  output logic [W-1:0]  pat_q
);
  import lcs_pkg::*;

  logic [W-1:0] pat_d;

  always_comb begin
    pat_d = pat_q;
    if (load_evt)
      pat_d = W'(32'(load_pat) & lcs_mask(int'(load_len)));
    else if (step_evt)
      pat_d = W'(lcs_rotate(32'(pat_q), int'(len), dir));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pat_q <= '0;
    else        pat_q <= pat_d;
  end

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(pat_q) & ~lcs_mask(int'(len))) == 32'h0);

  assert_step_keeps_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !load_evt) |=> ($countones(pat_q) == $countones($past(pat_q))));

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_evt && !load_evt) |=> $stable(pat_q));

endmodule

// File: rtl/circ_seg_shifter.sv
module circ_seg_shifter #(
  parameter int unsigned W    = 16,
  parameter int unsigned NSRC = 3,
  localparam int unsigned SW  = $clog2(NSRC + 1),
  localparam int unsigned LW  = $clog2(W) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [NSRC-1:0] tick,
  input  logic            cfg_we,
  input  logic [SW-1:0]   cfg_src,
  input  logic            cfg_dir,
  input  logic [LW-1:0]   cfg_len,
  input  logic [W-1:0]    cfg_pattern,
  output logic [W-1:0]    pattern_out
);
  logic          load_evt;
  logic          step_evt;
  logic [LW-1:0] load_len;
  logic [SW-1:0] src_q;
  logic          dir_q;
  logic [LW-1:0] len_q;

  lcs_cfg_regs #(.W(W), .SW(SW), .LW(LW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .cfg_src(cfg_src), .cfg_dir(cfg_dir), .cfg_len(cfg_len),
    .load_evt(load_evt), .load_len(load_len),
    .src_q(src_q), .dir_q(dir_q), .len_q(len_q)
  );

  lcs_tick_sel #(.NSRC(NSRC), .SW(SW)) u_sel (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .src(src_q), .step_evt(step_evt)
  );

  lcs_rot_core #(.W(W), .LW(LW)) u_core (
    .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .load_pat(cfg_pattern),
    .load_len(load_len), .step_evt(step_evt), .dir(dir_q), .len(len_q),
    .pat_q(pattern_out)
  );

  assert_locked_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && enable && !step_evt) |=> $stable(pattern_out));

endmodule

// File: tb/test_circ_seg_shifter.sv
module test_circ_seg_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [2:0]  tick = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_src = '0;
  logic        cfg_dir = 1'b0;
  logic [4:0]  cfg_len = '0;
  logic [15:0] cfg_pattern = '0;
  logic [15:0] pattern_out;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0] m_pat = '0;
  int          m_len = 16;
  logic        m_dir = 1'b0;
  int          m_src = 0;

  always #4 clk = ~clk;

  circ_seg_shifter i_circ_seg_shifter (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_dir(cfg_dir),
    .cfg_len(cfg_len), .cfg_pattern(cfg_pattern), .pattern_out(pattern_out)
  );

  function automatic logic [15:0] b_keep(input logic [15:0] p, input int n);
    logic [15:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = p[i];
    return r;
  endfunction

  function automatic logic [15:0] b_turn(input logic [15:0] p, input int n, input logic d);
    logic [15:0] r = '0;
    for (int i = 0; i < n; i++) begin
      if (!d) r[(i + 1) % n] = p[i];
      else    r[(i + n - 1) % n] = p[i];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (pattern_out !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, pattern_out, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [1:0] src, input logic dir,
                     input logic [4:0] len, input logic [15:0] pat,
                     input logic [2:0] tk, input logic en, input string req);
    @(negedge clk);
    cfg_we = we; cfg_src = src; cfg_dir = dir; cfg_len = len;
    cfg_pattern = pat; tick = tk; enable = en;
    @(posedge clk);
    if (we && !en) begin
      m_len = (len == 0 || len > 16) ? 16 : int'(len);
      m_src = int'(src);
      m_dir = dir;
      m_pat = b_keep(pat, m_len);
    end else if (en && m_src < 3 && tk[m_src]) begin
      m_pat = b_turn(m_pat, m_len, m_dir);
    end
    #1;
    check(req, m_pat);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL R7 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset", 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, 3'b001, 1, "R1 default rotate of zero");
    // R2/R3 load with upper bits masked
    cyc(1, 0, 0, 5'd8, 16'hFF81, 3'b000, 0, "R2 R3 load len8");
    // R4 left wrap
    cyc(0, 0, 0, 0, 0, 3'b001, 1, "R4 left wrap");
    // R6 unselected tick
    cyc(0, 0, 0, 0, 0, 3'b110, 1, "R6 unselected tick");
    // R8 disabled
    cyc(0, 0, 0, 0, 0, 3'b111, 0, "R8 disabled hold");
    // R5 right wrap
    cyc(1, 2'd1, 1, 5'd5, 16'h0001, 3'b000, 0, "R2 load len5");
    cyc(0, 0, 0, 0, 0, 3'b010, 1, "R5 right wrap");
    // R9 locked write
    cyc(1, 2'd0, 0, 5'd3, 16'hFFFF, 3'b000, 1, "R9 locked write hold");
    cyc(1, 2'd0, 0, 5'd3, 16'hFFFF, 3'b010, 1, "R9 locked write rotate");
    cyc(0, 0, 0, 0, 0, 3'b010, 1, "R9 config kept");
    // R2 length 0 means 16
    cyc(1, 0, 0, 5'd0, 16'h8000, 3'b000, 0, "R2 len0 load");
    cyc(0, 0, 0, 0, 0, 3'b001, 1, "R2 R4 len16 wrap");
    cyc(1, 0, 1, 5'd20, 16'h0001, 3'b000, 0, "R2 len20 load");
    cyc(0, 0, 0, 0, 0, 3'b001, 1, "R5 len16 right wrap");
    // R10 length 1
    cyc(1, 0, 0, 5'd1, 16'h0003, 3'b000, 0, "R10 len1 load");
    cyc(0, 0, 0, 0, 0, 3'b001, 1, "R10 len1 step");
    // R6 source 3
    cyc(1, 2'd3, 0, 5'd6, 16'h0005, 3'b000, 0, "R6 src3 load");
    cyc(0, 0, 0, 0, 0, 3'b111, 1, "R6 src3 no step");
    // R7 consecutive pulses
    cyc(1, 2'd2, 0, 5'd6, 16'h0005, 3'b000, 0, "R7 load");
    for (int k = 0; k < 7; k++) cyc(0, 0, 0, 0, 0, 3'b100, 1, "R7 back to back");
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic we = ($urandom % 8) == 0;
      cyc(we, 2'($urandom), 1'($urandom), 5'($urandom), 16'($urandom),
          3'($urandom), ($urandom % 4) != 0, "R3 R4 R5 R6 R7 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule